// File: doc/BRIEF.md
# Half-Step Clock Source Divider

This block derives an output clock from one of five reference sources. Its divider works in steps of half a source period, so the division ratio runs from 1 up to 32.5 in increments of 0.5. The whole block runs on one fast system clock. Each reference is presented as an edge strobe: a single-cycle pulse, synchronous to the system clock, for every rising and every falling edge of that reference. The output `div_clk` is a registered level. Each of its periods spans a fixed number of strobes from the selected source.

Two 32-bit configuration words are written through a simple write port. The source word selects the reference. The divider word holds an enable flag and a 6-bit divide code. A written value waits in a pending copy and moves to the active copy only when the current output period ends. This keeps runt pulses off the output. When no usable source is active, the update takes effect on the next cycle instead.

Top module: `hsdiv_top`

## Requirements
- R1: After reset `div_clk` is 0 and `no_clk` is 0. The active setting is the crystal source with the divider disabled.
- R2: A source word whose bits 1:0 equal 0 selects the crystal strobe `xtal_edge`. If bits 17:16 are both 1, it selects the 108 MHz strobe `ref108_edge` instead. A single set bit among 17:16 still selects the crystal.
- R3: Source code 2 (bits 1:0) selects `ref100_edge`. Source code 3 selects the oscillator path: `vco0_edge` when bit 8 is 0, and `vco1_edge` when bit 8 is 1.
- R4: Source code 1 is invalid. Once it is active, `no_clk` is 1, `div_clk` is 0, and strobes on every input leave `div_clk` at 0.
- R5: When bit 31 of the divider word is 1, one output period lasts N = code+2 strobes of the selected source, where code is bits 5:0. The output frequency is therefore 2·f_in/(code+2).
- R6: Each output period begins with a high phase of ceil(N/2) strobes, followed by a low phase of floor(N/2) strobes.
- R7: When bit 31 of the divider word is 0, `div_clk` toggles on every selected strobe (pass-through, N = 2), whatever the code field holds.
- R8: `cfg_addr` 0 writes the source word and `cfg_addr` 1 writes the divider word. A written value becomes active on the strobe that ends the current output period. If the invalid source is active, the value becomes active on the clock edge after the write.
- R9: Strobes on sources that are not selected leave `div_clk` unchanged.
- R10: `div_clk` changes only on the clock edge that samples a selected strobe. The first selected strobe after a valid source becomes active starts a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: source word, 1: divider word |
| cfg_wdata | input | 32 | Configuration write data |
| xtal_edge | input | 1 | Crystal edge strobe |
| ref108_edge | input | 1 | 108 MHz reference edge strobe |
| ref100_edge | input | 1 | 100 MHz reference edge strobe |
| vco0_edge | input | 1 | First oscillator edge strobe |
| vco1_edge | input | 1 | Second oscillator edge strobe |
| div_clk | output | 1 | Divided output clock level |
| no_clk | output | 1 | High while the invalid source is active |

## Verification
Every divide code from 0 to 63 is exercised, and each code's output is compared, strobe by strobe, against the closed-form high/low pattern of ceil(N/2) and floor(N/2) over at least two full periods. This separates odd ratios from even ones and catches any off-by-one in the period length. The sweep rotates through all five sources, including a source word with only bit 16 set. Between selected strobes, the other sources are pulsed, which shows whether the selection decode picks the wrong input. Separate sequences change the divide code and the source in the middle of a period, which tells a boundary-deferred update apart from an immediate one. Pass-through mode and the invalid source are also checked for their fixed toggle and held-low behaviour.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

    localparam int WORD_W   = 32;
    localparam int CODE_W   = 6;
    localparam int CNT_W    = CODE_W + 1;
    localparam int NSRC     = 5;

    // bit positions inside the configuration words
    localparam int KIND_LSB = 0;
    localparam int VCO_BIT  = 8;
    localparam int ALT_LSB  = 16;
    localparam int EN_BIT   = 31;
    localparam int CODE_LSB = 0;

    typedef enum logic [1:0] {
        SRC_LOW   = 2'd0,
        SRC_BAD   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_OSC   = 2'd3
    } src_kind_e;

    typedef enum logic [2:0] {
        PICK_XTAL = 3'd0,
        PICK_R108 = 3'd1,
        PICK_R100 = 3'd2,
        PICK_OSC0 = 3'd3,
        PICK_OSC1 = 3'd4,
        PICK_NONE = 3'd5
    } pick_e;

    typedef struct packed {
        src_kind_e kind;
        logic      alt;
        logic      osc_b;
    } src_cfg_t;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } div_cfg_t;

    typedef struct packed {
        src_cfg_t src;
        div_cfg_t div;
    } cfg_t;

    localparam cfg_t RST_CFG = '{
        src: '{kind: SRC_LOW, alt: 1'b0, osc_b: 1'b0},
        div: '{en: 1'b0, code: '0}
    };

    function automatic src_cfg_t decode_src(input logic [WORD_W-1:0] w);
        src_cfg_t s;
        s.kind  = src_kind_e'(w[KIND_LSB +: 2]);
        s.alt   = &w[ALT_LSB +: 2];
        s.osc_b = w[VCO_BIT];
        return s;
    endfunction

    function automatic div_cfg_t decode_div(input logic [WORD_W-1:0] w);
        div_cfg_t d;
        d.en   = w[EN_BIT];
        d.code = w[CODE_LSB +: CODE_W];
        return d;
    endfunction

    function automatic pick_e pick_of(input src_cfg_t s);
        case (s.kind)
            SRC_LOW:   return s.alt ? PICK_R108 : PICK_XTAL;
            SRC_FIXED: return PICK_R100;
            SRC_OSC:   return s.osc_b ? PICK_OSC1 : PICK_OSC0;
            default:   return PICK_NONE;
        endcase
    endfunction

    // strobes per output period
    function automatic logic [CNT_W-1:0] half_count(input div_cfg_t d);
        return d.en ? (CNT_W'(d.code) + CNT_W'(2)) : CNT_W'(2);
    endfunction

endpackage

// File: rtl/hsdiv_cfg.sv
module hsdiv_cfg
    import hsdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                boundary,
    output cfg_t                act_q,
    output logic                nxt_bad,
    output logic [CNT_W-1:0]    nxt_n
);

    cfg_t pend_q;
    cfg_t nxt;
    logic dirty_q;
    logic act_bad;
    logic apply;

    assign act_bad = (act_q.src.kind == SRC_BAD);
    assign apply   = dirty_q && (act_bad || boundary);
    assign nxt     = apply ? pend_q : act_q;
    assign nxt_bad = (nxt.src.kind == SRC_BAD);
    assign nxt_n   = half_count(nxt.div);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= RST_CFG;
            act_q   <= RST_CFG;
            dirty_q <= 1'b0;
        end else begin
            if (apply) begin
                act_q   <= pend_q;
                dirty_q <= 1'b0;
            end
            if (we) begin
                if (addr) pend_q.div <= decode_div(wdata);
                else      pend_q.src <= decode_src(wdata);
                dirty_q <= 1'b1;
            end
        end
    end

    // R8: active setting only moves at a period end or while dead
    p_hold_until_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !act_bad) |=> $stable(act_q));

endmodule

// File: rtl/hsdiv_srcmux.sv
module hsdiv_srcmux
    import hsdiv_pkg::*;
#(
    parameter int N_IN = NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  src_cfg_t        sel,
    input  logic [N_IN-1:0] strobe,
    output logic            ev
);

    pick_e           pick;
    logic [N_IN-1:0] hit;

    assign pick = pick_of(sel);

    for (genvar i = 0; i < N_IN; i++) begin : g_hit
        assign hit[i] = (pick == pick_e'(3'(i))) && strobe[i];
    end

    assign ev = |hit;

    // R4: a dead source never produces an event
    p_dead_no_event_r4: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == SRC_BAD) |-> !ev);

endmodule

// File: rtl/hsdiv_core.sv
module hsdiv_core
    import hsdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev,
    input  logic             act_bad,
    input  logic [CNT_W-1:0] act_n,
    input  logic             nxt_bad,
    input  logic [CNT_W-1:0] nxt_n,
    output logic             boundary,
    output logic             div_clk
);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] rem_dec;
    logic [CNT_W-1:0] low_len;

    assign rem_dec  = rem_q - CNT_W'(1);
    assign low_len  = act_n >> 1;
    assign boundary = ev && (rem_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            div_clk <= 1'b0;
        end else if (nxt_bad) begin
            rem_q   <= '0;
            div_clk <= 1'b0;
        end else if (ev) begin
            if (rem_q == '0) begin
                rem_q   <= nxt_n - CNT_W'(1);
                div_clk <= 1'b1;
            end else begin
                rem_q   <= rem_dec;
                div_clk <= (rem_dec >= low_len);
            end
        end
    end

    // R4: output held low while no clock is selected
    p_dead_low_r4: assert property (@(posedge clk) disable iff (rst)
        act_bad |-> !div_clk);

    // R10: output moves only after a selected strobe
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !ev |=> $stable(div_clk));

    // R5: position within the period stays inside the period length
    p_rem_range_r5: assert property (@(posedge clk) disable iff (rst)
        rem_q < act_n);

endmodule

// File: rtl/hsdiv_top.sv
module hsdiv_top
    import hsdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              xtal_edge,
    input  logic              ref108_edge,
    input  logic              ref100_edge,
    input  logic              vco0_edge,
    input  logic              vco1_edge,
    output logic              div_clk,
    output logic              no_clk
);

    cfg_t             act;
    logic             nxt_bad;
    logic [CNT_W-1:0] nxt_n;
    logic [CNT_W-1:0] act_n;
    logic             act_bad;
    logic             ev;
    logic             boundary;
    logic [NSRC-1:0]  strobes;

    // order follows pick_e
    assign strobes = {vco1_edge, vco0_edge, ref100_edge, ref108_edge, xtal_edge};
    assign act_n   = half_count(act.div);
    assign act_bad = (act.src.kind == SRC_BAD);
    assign no_clk  = act_bad;

    hsdiv_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .boundary (boundary),
        .act_q    (act),
        .nxt_bad  (nxt_bad),
        .nxt_n    (nxt_n)
    );

    hsdiv_srcmux #(.N_IN(NSRC)) u_mux (
        .clk    (clk),
        .rst    (rst),
        .sel    (act.src),
        .strobe (strobes),
        .ev     (ev)
    );

    hsdiv_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .act_bad  (act_bad),
        .act_n    (act_n),
        .nxt_bad  (nxt_bad),
        .nxt_n    (nxt_n),
        .boundary (boundary),
        .div_clk  (div_clk)
    );

endmodule

// File: tb/hsdiv_top_tb.sv
module hsdiv_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [4:0]  stb = '0;
    logic        div_clk;
    logic        no_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsdiv_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .xtal_edge   (stb[0]),
        .ref108_edge (stb[1]),
        .ref100_edge (stb[2]),
        .vco0_edge   (stb[3]),
        .vco1_edge   (stb[4]),
        .div_clk     (div_clk),
        .no_clk      (no_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input bit addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] mask);
        @(negedge clk);
        stb = mask;
        @(negedge clk);
        stb = '0;
    endtask

    // source words: R2 crystal (single alt bit), R2 108, R3 100, R3 osc0, R3 osc1
    function automatic logic [31:0] selword(input int s);
        case (s)
            0:       return 32'h0001_0000;
            1:       return 32'h0003_0000;
            2:       return 32'h0000_0002;
            3:       return 32'h0000_0003;
            default: return 32'h0000_0103;
        endcase
    endfunction

    function automatic bit exp_level(input int k, input int n);
        return (k % n) < ((n + 1) / 2);
    endfunction

    task automatic go_dead();
        wr(1'b0, 32'h0000_0001);
        for (int i = 0; i < 70; i++) begin
            if (no_clk) break;
            pulse(5'h1f);
        end
        check(no_clk == 1'b1, "R4 no_clk", no_clk, 1);
        check(div_clk == 1'b0, "R4 low", div_clk, 0);
    endtask

    task automatic run_events(input int s, input int n, input int k0, input int cnt, input string req);
        for (int k = k0; k < k0 + cnt; k++) begin
            logic prev;
            pulse(5'(1 << s));
            check(div_clk == exp_level(k, n), req, div_clk, int'(exp_level(k, n)));
            prev = div_clk;
            pulse(~5'(1 << s));
            check(div_clk == prev, "R9 other sources", div_clk, prev);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(div_clk == 1'b0, "R1 div_clk", div_clk, 0);
        check(no_clk == 1'b0, "R1 no_clk", no_clk, 0);
        // R1: crystal pass-through from reset
        run_events(0, 2, 0, 4, "R1 reset pass-through");

        // R5 R6 R2 R3 sweep of every code across the sources
        for (int code = 0; code < 64; code++) begin
            int s = code % 5;
            go_dead();
            wr(1'b1, 32'h8000_0000 | code);
            wr(1'b0, selword(s));
            @(negedge clk);
            check(no_clk == 1'b0, "R8 immediate apply when dead", no_clk, 0);
            check(div_clk == 1'b0, "R10 idle before strobe", div_clk, 0);
            run_events(s, code + 2, 0, 2 * (code + 2) + 1, "R5 R6 R10 pattern");
        end

        // R7 pass-through ignores code field
        go_dead();
        wr(1'b1, 32'h0000_0025);
        wr(1'b0, selword(2));
        run_events(2, 2, 0, 8, "R7 pass-through");

        // R8 change of code mid-period waits for the boundary
        go_dead();
        wr(1'b1, 32'h8000_0008);
        wr(1'b0, selword(4));
        run_events(4, 10, 0, 3, "R8 before change");
        wr(1'b1, 32'h8000_0000);
        run_events(4, 10, 3, 7, "R8 old ratio kept");
        run_events(4, 2, 0, 7, "R8 new ratio");

        // R8 R4 invalid source mid-period
        wr(1'b0, 32'h0000_0001);
        check(no_clk == 1'b0, "R8 pending invalid", no_clk, 0);
        pulse(5'b10000);
        check(div_clk == 1'b0, "R8 period finishes", div_clk, 0);
        check(no_clk == 1'b0, "R8 still active", no_clk, 0);
        pulse(5'b10000);
        check(no_clk == 1'b1, "R8 R4 dead at boundary", no_clk, 1);
        check(div_clk == 1'b0, "R4 low at boundary", div_clk, 0);
        for (int i = 0; i < 3; i++) begin
            pulse(5'h1f);
            check(div_clk == 1'b0, "R4 strobes ignored", div_clk, 0);
        end

        // R2 108 path chosen over crystal
        wr(1'b1, 32'h8000_0001);
        wr(1'b0, selword(1));
        run_events(1, 3, 0, 7, "R2 108 path");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule